// File: doc/BRIEF.md
# PHY Management Serial Access Controller

This block gives software access to the management registers of external Ethernet PHYs over the two-wire MDC/MDIO management bus. Software sees two 32-bit registers. The access register holds the PHY number, the register number, a direction bit and a busy flag. The data register holds the 16-bit value: the value to be written, or the value that comes back on a read.

For a write, software first loads the data register. It then writes the access register with the direction bit set. For a read, it writes the access register with the direction bit clear. The write to the access register starts a 64-bit management frame, which the controller shifts out on MDIO while it generates MDC. Software polls the busy flag until it clears. After a read, the data register then holds the returned value in its low half.

MDC runs only while a frame is in progress. Its frequency is the system clock divided by an even parameter.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset both software registers read as zero, MDC is low and MDIO is not driven (`mdio_oe` low).
- R2: Access register layout: bits 15:11 hold the PHY address, bits 10:6 the register number, bit 1 is the direction (1 = write, 0 = read) and bit 0 the busy flag. Bits 31:16 and 5:2 always read as zero, whatever was written there.
- R3: A write to the access register (`csr_sel` = 0) while idle starts a frame. Bit 0 reads 1 from the following cycle until the frame ends.
- R4: While busy, MDC has a period of `CLK_DIV` clock cycles with equal high and low halves. Each frame has exactly 64 MDC rising edges. When idle, MDC is held low.
- R5: The frame is sent MSB first, with MDIO changing on the falling edge of MDC. Its fields in order are: 32 ones, start bits 01, opcode (10 for read, 01 for write), the 5-bit PHY address, the 5-bit register number, turnaround 10 (write only), and 16 data bits.
- R6: On a read, MDIO is released (`mdio_oe` low) for the two turnaround bits and the 16 data bits. `mdio_i` is sampled on each of the 16 data rising edges of MDC. When busy clears, the data register reads {16'h0000, the sampled word}.
- R7: On a write, the data bits of the frame are the low 16 bits of the data register, and the data register keeps its value after the frame.
- R8: A write to the access register while busy is ignored: the fields read back and the frame on the wire stay those of the transfer in progress.
- R9: A write to the data register (`csr_sel` = 1) updates it when idle and is ignored while busy.
- R10: Busy stays set for exactly 64 × `CLK_DIV` clock cycles per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | Register select: 0 access register, 1 data register |
| csr_wdata | input | 32 | Register write data |
| csr_addr_rdata | output | 32 | Access register read value |
| csr_data_rdata | output | 32 | Data register read value |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven out |
| mdio_oe | output | 1 | Output enable for MDIO |
| mdio_i | input | 1 | Management data from the PHYs |

## Verification
The hardest situation to reach from the ports is a register write that lands in the middle of a running frame. Such a write has to be dropped, and it must not disturb the bits already on the wire, the fields read back, or a read result that arrives later. The bench counts cycles inside each transfer and injects, at a fixed point deep in the frame, an access-register write with flipped fields or a data-register write. It then checks the captured frame and both registers once busy clears. Random PHY numbers, register numbers, directions, reserved-bit junk and data words are mixed with directed all-zero and all-one words.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int MD_W      = 16;
  localparam int CSR_W     = 32;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_W + REG_W + 2 + MD_W;
  localparam int TA_IDX    = FRAME_LEN - MD_W - 2;
  localparam int DAT_IDX   = FRAME_LEN - MD_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int PHY_LSB   = 11;
  localparam int REG_LSB   = 6;
  localparam int WR_BIT    = 1;

  typedef struct packed {
    logic [PHY_W-1:0] phy;
    logic [REG_W-1:0] regad;
    logic             wr;
  } mgmt_req_t;

  // Serial image of one management frame, leftmost bit sent first
  function automatic logic [FRAME_LEN-1:0] frame_of(input mgmt_req_t r,
                                                     input logic [MD_W-1:0] d);
    logic [1:0] op;
    op = r.wr ? 2'b01 : 2'b10;
    return {{PRE_LEN{1'b1}}, 2'b01, op, r.phy, r.regad, 2'b10,
            (r.wr ? d : {MD_W{1'b1}})};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  initial div_even_chk: assert (DIV >= 2 && (DIV % 2) == 0);

  assign tick     = en && (cnt_q == CW'(HALF - 1));
  assign rise_stb = tick && !mdc_q;
  assign fall_stb = tick && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  mgmt_req_t       req,
  input  logic [MD_W-1:0] tx_data,
  input  logic            rise_stb,
  input  logic            fall_stb,
  input  logic            mdio_i,
  output logic            busy,
  output logic            done,
  output logic            done_rd,
  output logic [MD_W-1:0] rx_word,
  output logic            mdio_o,
  output logic            mdio_oe
);
  logic [FRAME_LEN-1:0] sh_q;
  logic [CNT_W-1:0]     bit_q;
  logic [CNT_W-1:0]     bit_nxt;
  logic                 busy_q, rd_q, mdo_q, oe_q, last_bit;
  logic [MD_W-1:0]      cap_q;

  assign bit_nxt  = bit_q + 1'b1;
  assign last_bit = (bit_q == CNT_W'(FRAME_LEN - 1));
  assign done     = busy_q && fall_stb && last_bit;
  assign done_rd  = rd_q;
  assign busy     = busy_q;
  assign rx_word  = cap_q;
  assign mdio_o   = mdo_q;
  assign mdio_oe  = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      mdo_q  <= 1'b1;
      oe_q   <= 1'b0;
      cap_q  <= '0;
    end else if (start && !busy_q) begin
      sh_q   <= frame_of(req, tx_data);
      mdo_q  <= 1'b1;
      oe_q   <= 1'b1;
      bit_q  <= '0;
      rd_q   <= !req.wr;
      busy_q <= 1'b1;
      cap_q  <= '0;
    end else if (busy_q) begin
      if (rise_stb && rd_q && bit_q >= CNT_W'(DAT_IDX))
        cap_q <= {cap_q[MD_W-2:0], mdio_i};
      if (fall_stb) begin
        if (last_bit) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          mdo_q  <= 1'b1;
        end else begin
          bit_q <= bit_nxt;
          sh_q  <= sh_q << 1;
          mdo_q <= sh_q[FRAME_LEN-2];
          oe_q  <= !(rd_q && bit_nxt >= CNT_W'(TA_IDX));
        end
      end
    end
  end

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && rd_q && bit_q >= CNT_W'(TA_IDX) |-> !oe_q);
  // R1
  idle_float_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !oe_q);
  // R10
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy_q);
  // R5
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && !fall_stb |=> $stable(bit_q));
endmodule

// File: rtl/mdio_mgmt_csr.sv
`timescale 1ns/1ps
module mdio_mgmt_csr
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             sel,
  input  logic [CSR_W-1:0] wdata,
  input  logic             busy,
  input  logic             done,
  input  logic             done_rd,
  input  logic [MD_W-1:0]  rx_word,
  output logic             start,
  output mgmt_req_t        req_nxt,
  output logic [MD_W-1:0]  tx_data,
  output logic [CSR_W-1:0] addr_rd,
  output logic [CSR_W-1:0] data_rd
);
  mgmt_req_t        req_q;
  logic [CSR_W-1:0] data_q;
  logic             data_wr;

  assign start         = we && !sel && !busy;
  assign data_wr       = we && sel && !busy;
  assign req_nxt.phy   = wdata[PHY_LSB +: PHY_W];
  assign req_nxt.regad = wdata[REG_LSB +: REG_W];
  assign req_nxt.wr    = wdata[WR_BIT];
  assign tx_data       = data_q[MD_W-1:0];
  assign data_rd       = data_q;
  assign addr_rd       = {{(CSR_W-PHY_LSB-PHY_W){1'b0}}, req_q.phy, req_q.regad,
                          {(REG_LSB-WR_BIT-1){1'b0}}, req_q.wr, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      data_q <= '0;
    end else begin
      if (start) req_q <= req_nxt;
      if (data_wr) data_q <= wdata;
      else if (done && done_rd) data_q <= {{(CSR_W-MD_W){1'b0}}, rx_word};
    end
  end

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(req_q));
  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> $stable(data_q));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        csr_we,
  input  logic        csr_sel,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_addr_rdata,
  output logic [31:0] csr_data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic            start, busy, done, done_rd, rise_stb, fall_stb;
  mgmt_req_t       req_nxt;
  logic [MD_W-1:0] tx_data, rx_word;

  mdio_mgmt_csr u_csr (
    .clk(clk), .rst(rst), .we(csr_we), .sel(csr_sel), .wdata(csr_wdata),
    .busy(busy), .done(done), .done_rd(done_rd), .rx_word(rx_word),
    .start(start), .req_nxt(req_nxt), .tx_data(tx_data),
    .addr_rd(csr_addr_rdata), .data_rd(csr_data_rdata)
  );

  mdio_clk_div #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst(rst), .en(busy), .mdc(mdc),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst(rst), .start(start), .req(req_nxt), .tx_data(tx_data),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .done(done), .done_rd(done_rd), .rx_word(rx_word),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  // R3
  busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(csr_we && !csr_sel));
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
  localparam int DIV   = 8;
  localparam int HALF  = DIV / 2;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic        csr_sel = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_addr_rdata, csr_data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int rcnt = 0;
  int base = 0;
  int rise_cyc = 0;
  int period = 0;
  int high_len = 0;
  logic [63:0] frame_cap = '0;
  logic [63:0] oe_cap = '0;
  logic [15:0] phy_val = '0;

  mdio_mgmt_ctrl #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_addr_rdata(csr_addr_rdata),
    .csr_data_rdata(csr_data_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      $display("FAIL watchdog expired act=%0d exp<%0d", cyc, LIMIT);
      $display("  Result: errors=%0d of %0d checks", errs + 1, checks + 1);
      $finish;
    end
  end

  // PHY model: record what is on the wire at each MDC rise
  always @(posedge mdc) begin
    frame_cap = {frame_cap[62:0], mdio_o};
    oe_cap    = {oe_cap[62:0], mdio_oe};
    period    = cyc - rise_cyc;
    rise_cyc  = cyc;
    rcnt      = rcnt + 1;
  end

  always @(negedge mdc) begin
    int k;
    high_len = cyc - rise_cyc;
    k = rcnt - base;
    if (k >= 48 && k <= 63) mdio_i = phy_val[63 - k];
  end

  function automatic logic [63:0] exp_frame(input logic [4:0] p, input logic [4:0] r,
                                            input logic w, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, w ? 2'b01 : 2'b10, p, r, 2'b10, w ? d : 16'hFFFF};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  // mode 0: plain, 1: access-register write mid-frame, 2: data write mid-frame
  task automatic xfer(input logic [4:0] p, input logic [4:0] r, input logic w,
                      input logic [15:0] d, input logic [15:0] pv, input int mode);
    int n;
    logic [31:0] junk;
    logic [63:0] ef;
    logic [31:0] data_before;
    junk = $urandom;
    if (w) reg_write(1'b1, {junk[31:16], d});
    else   reg_write(1'b1, junk);
    data_before = csr_data_rdata;
    // R9 idle data write takes effect
    chk(csr_data_rdata == (w ? {junk[31:16], d} : junk), "R9 idle data write",
        64'(csr_data_rdata), 64'(w ? {junk[31:16], d} : junk));
    phy_val = pv;
    base = rcnt;
    junk = $urandom;
    @(negedge clk);
    csr_we = 1'b1; csr_sel = 1'b0;
    csr_wdata = {junk[31:16], p, r, junk[5:2], w, junk[0]};
    @(negedge clk);
    csr_we = 1'b0;
    chk(csr_addr_rdata[0] == 1'b1, "R3 busy after start", 64'(csr_addr_rdata[0]), 64'd1);
    n = 1;
    while (n < 4000) begin
      @(negedge clk);
      if (n == 100 && mode == 1) begin
        csr_we = 1'b1; csr_sel = 1'b0;
        csr_wdata = {16'h0, ~p, ~r, 4'h0, ~w, 1'b0};
      end else if (n == 100 && mode == 2) begin
        csr_we = 1'b1; csr_sel = 1'b1; csr_wdata = 32'hDEAD_BEEF;
      end else begin
        csr_we = 1'b0;
      end
      if (csr_addr_rdata[0]) n++;
      else break;
    end
    csr_we = 1'b0;
    chk(n == 64 * DIV, "R10 busy length", 64'(n), 64'(64 * DIV));
    chk(csr_addr_rdata == {16'h0, p, r, 4'h0, w, 1'b0}, "R2/R8 access readback",
        64'(csr_addr_rdata), 64'({16'h0, p, r, 4'h0, w, 1'b0}));
    chk(rcnt - base == 64, "R4 rising edges per frame", 64'(rcnt - base), 64'd64);
    chk(period == DIV && high_len == HALF, "R4 mdc period/high",
        {32'(period), 32'(high_len)}, {32'(DIV), 32'(HALF)});
    ef = exp_frame(p, r, w, d);
    if (w) begin
      chk(frame_cap == ef, "R5/R7/R8 write frame", frame_cap, ef);
      chk(oe_cap == '1, "R5 write drives whole frame", oe_cap, '1);
      chk(csr_data_rdata == data_before, "R7/R9 data kept after write",
          64'(csr_data_rdata), 64'(data_before));
    end else begin
      chk(frame_cap[63:18] == ef[63:18], "R5/R8 read frame header",
          64'(frame_cap[63:18]), 64'(ef[63:18]));
      chk(oe_cap == {46'h3FFF_FFFF_FFFF, 18'h0}, "R6 read release",
          oe_cap, {46'h3FFF_FFFF_FFFF, 18'h0});
      chk(csr_data_rdata == {16'h0, pv}, "R6/R9 read result",
          64'(csr_data_rdata), 64'({16'h0, pv}));
    end
    @(negedge clk);
    chk(!mdc && !mdio_oe, "R4 idle mdc low and released", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(csr_addr_rdata == 0, "R1 access reg reset", 64'(csr_addr_rdata), 64'h0);
    chk(csr_data_rdata == 0, "R1 data reg reset", 64'(csr_data_rdata), 64'h0);
    chk(!mdc && !mdio_oe, "R1 mdc low and released", {62'h0, mdc, mdio_oe}, 64'h0);

    xfer(5'd0,  5'd1,  1'b0, 16'h0000, 16'h796D, 0);
    xfer(5'd31, 5'd31, 1'b1, 16'hFFFF, 16'h0000, 0);
    xfer(5'd1,  5'd0,  1'b1, 16'h0000, 16'h0000, 0);
    xfer(5'd16, 5'd4,  1'b0, 16'h0000, 16'hFFFF, 0);
    xfer(5'd2,  5'd3,  1'b0, 16'h0000, 16'h0000, 0);
    xfer(5'd10, 5'd21, 1'b0, 16'h0000, 16'hA5C3, 1);
    xfer(5'd21, 5'd10, 1'b1, 16'h1234, 16'h0000, 1);
    xfer(5'd7,  5'd9,  1'b0, 16'h0000, 16'h8001, 2);
    xfer(5'd9,  5'd7,  1'b1, 16'hC0DE, 16'h0000, 2);
    for (int i = 0; i < 20; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      xfer(rv[4:0], rv[9:5], rv[10], rv[31:16], 16'($urandom), int'(rv[12:11] % 3));
    end
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule